// File: doc/BRIEF.md
# Physical Interrupt Active-State Tracker

This block keeps a pending bit and an active bit for each of a small set of interrupt lines feeding one CPU. It asserts its request to the CPU only for a line that is pending and not active. The active bit is used on purpose as a hold-off. A level line that stays asserted, or an edge line that fires again, cannot interrupt the CPU again until the interrupt is deactivated. Deactivation may come from the host or be relayed from a guest's list-register logic.

Each line has one of three modes. A level line is pending exactly while its input is high. An edge line latches a rising edge into its pending bit. An active-less line is also edge-latched, but it never enters the active state. A host acknowledge returns the lowest-numbered forwardable line and makes it active. Software can also make a line active without any acknowledge, which parks an interrupt that was never taken on the host. Deactivation is kept separate from the host's end of handler. A line can therefore stay active after the handler finishes, and on release the block resamples the line or the latched edge.

Top module: `irq_hold_tracker`

## Requirements
- R1: After reset every active bit and every latched edge is clear, so `act_q`, `pend_view`, `irq_out` and `ack_valid` are all zero while inputs are low.
- R2: `mode_cfg[2i+1:2i]` selects the mode of line i: 00 is level, 01 is edge, and 1x is active-less. For a level line, `pend_view[i]` equals `line_in[i]` in the same cycle.
- R3: `irq_out` is high exactly when some line has its `pend_view` bit set and its `act_q` bit clear. An active line never raises it.
- R4: While `ack_req` is high and `irq_out` is high, `ack_valid` is high and `ack_id` is the lowest forwardable index, in the same cycle. From the next cycle that line is active, unless it is active-less, and its latched edge, if any, is cleared.
- R5: When a level line is deactivated, `irq_out` is raised again if and only if its input is still high.
- R6: On an edge line, a rising input in cycle t sets `pend_view` from cycle t+1. Further edges while it is already pending merge, so a single acknowledge leaves it not pending.
- R7: A rising edge on an active edge line makes it pending and active at once, with `irq_out` staying low for that line.
- R8: After deactivation, an edge line forwards again if and only if an edge arrived while it was active.
- R9: A set-active command (`setact_req`, `setact_id`) makes a level or edge line active from the next cycle without any acknowledge, and holds off its pending state.
- R10: An active-less line becomes pending on a rising edge and is cleared by acknowledge. It never becomes active, and a set-active command aimed at it leaves `act_q` unchanged.
- R11: A deactivate command (`deact_req`, `deact_id`) for a line that is not active changes neither its active nor its pending state.
- R12: An acknowledge while nothing is forwardable gives `ack_valid` low and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_in | input | NLINES | Synchronous interrupt inputs |
| mode_cfg | input | 2*NLINES | Two mode bits per line (00 level, 01 edge, 1x active-less) |
| ack_req | input | 1 | Host acknowledge strobe |
| ack_valid | output | 1 | Acknowledge returned a line |
| ack_id | output | IDW | Index of the acknowledged line |
| setact_req | input | 1 | Software set-active strobe |
| setact_id | input | IDW | Line to make active |
| deact_req | input | 1 | Deactivate strobe |
| deact_id | input | IDW | Line to deactivate |
| irq_out | output | 1 | Interrupt request to the CPU |
| pend_view | output | NLINES | Pending state of each line |
| act_q | output | NLINES | Active state of each line |

## Verification
The hardest state to reach is an edge line that is both pending and active, because it requires a new edge after the acknowledge and before the deactivation. The stimulus acknowledges the line, pulses its input, and checks that the request stays low. It then deactivates the line and checks that the request reappears, and repeats the sequence with no pulse to show that the request stays low. A long pseudo-random phase mixes these commands on all modes against a behavioural reference model. That phase also covers same-cycle collisions, such as an edge arriving on the cycle of its own acknowledge.

// File: rtl/irq_hold_tracker.sv
module irq_hold_tracker #(
  parameter int NLINES = 8,
  localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NLINES-1:0] line_in,
  input  logic [2*NLINES-1:0] mode_cfg,
  input  logic              ack_req,
  output logic              ack_valid,
  output logic [IDW-1:0]    ack_id,
  input  logic              setact_req,
  input  logic [IDW-1:0]    setact_id,
  input  logic              deact_req,
  input  logic [IDW-1:0]    deact_id,
  output logic              irq_out,
  output logic [NLINES-1:0] pend_view,
  output logic [NLINES-1:0] act_q
);

  logic [NLINES-1:0] prev_line, edge_pend, is_lvl, is_lpi;
  logic [NLINES-1:0] rise, fwd, ack_hit, set_hit, deact_hit;

  for (genvar i = 0; i < NLINES; i++) begin : g_mode
    assign is_lpi[i] = mode_cfg[2*i+1];
    assign is_lvl[i] = ~mode_cfg[2*i+1] & ~mode_cfg[2*i];
  end

  assign rise      = line_in & ~prev_line;
  assign pend_view = (is_lvl & line_in) | (~is_lvl & edge_pend);
  assign fwd       = pend_view & ~act_q;
  assign irq_out   = |fwd;

  always_comb begin
    ack_id = '0;
    for (int i = NLINES - 1; i >= 0; i--)
      if (fwd[i]) ack_id = IDW'(i);
  end

  assign ack_valid = ack_req & irq_out;
  assign ack_hit   = ack_valid  ? (NLINES'(1) << ack_id) : '0;
  assign set_hit   = setact_req ? ((NLINES'(1) << setact_id) & ~is_lpi) : '0;
  assign deact_hit = deact_req  ? ((NLINES'(1) << deact_id) & act_q) : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_line <= '0;
      edge_pend <= '0;
      act_q     <= '0;
    end else begin
      prev_line <= line_in;
      edge_pend <= rise | (edge_pend & ~ack_hit);
      act_q     <= ~is_lpi & ((act_q & ~deact_hit) | ack_hit | set_hit);
    end
  end

endmodule

module irq_hold_tracker_chk #(
  parameter int NLINES = 8,
  localparam int IDW = (NLINES > 1) ? $clog2(NLINES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic [NLINES-1:0] line_in,
  input logic [2*NLINES-1:0] mode_cfg,
  input logic              ack_req,
  input logic              ack_valid,
  input logic [IDW-1:0]    ack_id,
  input logic              setact_req,
  input logic [IDW-1:0]    setact_id,
  input logic              deact_req,
  input logic [IDW-1:0]    deact_id,
  input logic              irq_out,
  input logic [NLINES-1:0] pend_view,
  input logic [NLINES-1:0] act_q
);

  a_r4_ack_not_active: assert property (@(posedge clk) disable iff (!rst_n)
    ack_valid |-> (!act_q[ack_id] && pend_view[ack_id]));

  a_r12_ack_needs_request: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_req && !irq_out) |-> !ack_valid);

  for (genvar i = 0; i < NLINES; i++) begin : g_chk
    a_r10_lpi_never_active: assert property (@(posedge clk) disable iff (!rst_n)
      mode_cfg[2*i+1] |-> !act_q[i]);

    a_r4_ack_makes_active: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_valid && ack_id == IDW'(i) && !mode_cfg[2*i+1]) |=> act_q[i]);

    a_r5_level_resample: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg[2*i+1:2*i] == 2'b00 && $fell(act_q[i]) && line_in[i]) |-> irq_out);

    a_r7_edge_while_active: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_cfg[2*i+1:2*i] == 2'b01 && act_q[i] && line_in[i] && !$past(line_in[i])
       && !(deact_req && deact_id == IDW'(i))) |=> (pend_view[i] && act_q[i]));

    a_r11_deact_idle_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (deact_req && deact_id == IDW'(i) && !act_q[i]
       && !(setact_req && setact_id == IDW'(i))
       && !(ack_valid && ack_id == IDW'(i))) |=> !act_q[i]);
  end

endmodule

bind irq_hold_tracker irq_hold_tracker_chk #(.NLINES(NLINES)) chk (.*);

// File: tb/irq_hold_tracker_test.sv
`timescale 1ns/1ps
module irq_hold_tracker_test;
  localparam int N = 8;
  localparam int W = 3;

  logic clk = 0;
  logic rst_n = 0;
  logic [N-1:0] line = '0;
  logic [2*N-1:0] mode;
  logic ack = 0, sa = 0, dq = 0;
  logic [W-1:0] sa_id = '0, dq_id = '0;
  logic ack_valid, irq_out;
  logic [W-1:0] ack_id;
  logic [N-1:0] pend_view, act_q;

  int checks = 0, errors = 0, cycles = 0;
  int m_pend[N], m_act[N], m_prev[N], m_mode[N];
  int lcg = 12345;

  always #5 clk = ~clk;

  irq_hold_tracker #(.NLINES(N)) uut (
    .clk(clk), .rst_n(rst_n), .line_in(line), .mode_cfg(mode),
    .ack_req(ack), .ack_valid(ack_valid), .ack_id(ack_id),
    .setact_req(sa), .setact_id(sa_id), .deact_req(dq), .deact_id(dq_id),
    .irq_out(irq_out), .pend_view(pend_view), .act_q(act_q));

  // modes: 0 level, 1 edge, 2 active-less
  initial begin
    for (int i = 0; i < N; i++) begin
      m_mode[i] = i % 3;
      mode[2*i +: 2] = (i % 3 == 0) ? 2'b00 : (i % 3 == 1) ? 2'b01 : 2'b10;
    end
  end

  task automatic check(input int act, input int exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int view(int i);
    return (m_mode[i] == 0) ? int'(line[i]) : m_pend[i];
  endfunction

  function automatic int lowest_fwd();
    for (int i = 0; i < N; i++)
      if (view(i) != 0 && m_act[i] == 0) return i;
    return -1;
  endfunction

  task automatic cyc();
    int k, av;
    int exp_pv, exp_act;
    #1;
    exp_pv = 0; exp_act = 0;
    for (int i = 0; i < N; i++) begin
      exp_pv  |= view(i) << i;
      exp_act |= m_act[i] << i;
    end
    k = lowest_fwd();
    av = (ack && k >= 0) ? 1 : 0;
    if (rst_n) begin
      check(int'(pend_view), exp_pv, "R2 R6 model pend_view");
      check(int'(act_q), exp_act, "R9 model act_q");
      check(int'(irq_out), (k >= 0) ? 1 : 0, "R3 model irq_out");
      check(int'(ack_valid), av, "R4 model ack_valid");
      if (av) check(int'(ack_id), k, "R4 model ack_id");
    end
    @(posedge clk);
    if (!rst_n) begin
      for (int i = 0; i < N; i++) begin m_pend[i] = 0; m_act[i] = 0; m_prev[i] = 0; end
    end else begin
      for (int i = 0; i < N; i++) begin
        int rise, hit_ack, hit_set, hit_dq;
        rise    = (line[i] && !m_prev[i]) ? 1 : 0;
        hit_ack = (av && k == i) ? 1 : 0;
        hit_set = (sa && sa_id == i && m_mode[i] != 2) ? 1 : 0;
        hit_dq  = (dq && dq_id == i && m_act[i]) ? 1 : 0;
        m_pend[i] = (rise || (m_pend[i] && !hit_ack)) ? 1 : 0;
        m_act[i]  = (m_mode[i] == 2) ? 0 :
                    (((m_act[i] && !hit_dq) || hit_ack || hit_set) ? 1 : 0);
        m_prev[i] = line[i];
      end
    end
    @(negedge clk);
  endtask

  task automatic deact(input int id);
    dq = 1; dq_id = W'(id); cyc(); dq = 0;
  endtask

  task automatic do_ack();
    ack = 1; cyc(); ack = 0;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    cyc(); cyc();
    rst_n = 1;
    #1;
    check(int'(act_q), 0, "R1 reset act_q");
    check(int'(pend_view), 0, "R1 reset pend_view");
    check(int'(irq_out), 0, "R1 reset irq_out");
    cyc();

    // level line 0
    line[0] = 1; cyc();
    check(int'(pend_view[0]), 1, "R2 level pending follows line");
    check(int'(irq_out), 1, "R3 level forwards");
    ack = 1; #1;
    check(int'(ack_valid), 1, "R4 ack valid"); check(int'(ack_id), 0, "R4 ack id");
    cyc(); ack = 0;
    check(int'(act_q[0]), 1, "R4 ack makes active");
    check(int'(irq_out), 0, "R3 active line held off");
    deact(0);
    check(int'(irq_out), 1, "R5 level resample high");
    do_ack();
    line[0] = 0; deact(0);
    check(int'(irq_out), 0, "R5 level resample low");

    // edge line 1
    line[1] = 1; cyc(); line[1] = 0; cyc();
    check(int'(pend_view[1]), 1, "R6 edge latched");
    line[1] = 1; cyc(); line[1] = 0; cyc();
    do_ack();
    check(int'(pend_view[1]), 0, "R6 merged edges cleared by one ack");
    check(int'(act_q[1]), 1, "R4 edge active after ack");
    line[1] = 1; cyc(); line[1] = 0; cyc();
    check(int'(pend_view[1] & act_q[1]), 1, "R7 pending and active");
    check(int'(irq_out), 0, "R7 held off while active");
    deact(1);
    check(int'(irq_out), 1, "R8 edge during active reforwards");
    do_ack();
    deact(1);
    check(int'(irq_out), 0, "R8 no edge no reforward");

    // set-active on level line 3
    sa = 1; sa_id = 3; cyc(); sa = 0;
    check(int'(act_q[3]), 1, "R9 set active without ack");
    line[3] = 1; cyc();
    check(int'(irq_out), 0, "R9 set active holds off");
    deact(3);
    check(int'(irq_out), 1, "R5 after software active");
    line[3] = 0; cyc();

    // active-less line 2
    line[2] = 1; cyc(); line[2] = 0;
    sa = 1; sa_id = 2; cyc(); sa = 0;
    check(int'(act_q[2]), 0, "R10 set active ignored");
    check(int'(irq_out), 1, "R10 still forwarded");
    ack = 1; #1; check(int'(ack_id), 2, "R10 ack id"); cyc(); ack = 0;
    check(int'(pend_view[2]), 0, "R10 ack clears pending");
    check(int'(act_q[2]), 0, "R10 never active");

    // deactivate of idle line
    line[4] = 1; cyc(); line[4] = 0;
    deact(4);
    check(int'(pend_view[4]), 1, "R11 pending kept");
    check(int'(act_q[4]), 0, "R11 active unchanged");
    do_ack(); deact(4);

    // ack with nothing forwardable
    ack = 1; #1; check(int'(ack_valid), 0, "R12 no valid"); cyc(); ack = 0;
    check(int'(act_q), 0, "R12 no state change");

    // priority
    line[6] = 1; line[1] = 1; cyc(); line[1] = 0; cyc();
    ack = 1; #1; check(int'(ack_id), 1, "R4 lowest index first"); cyc();
    #1; check(int'(ack_id), 6, "R4 next index"); cyc(); ack = 0;
    line[6] = 0; deact(1); deact(6);

    // random phase
    for (int n = 0; n < 3000; n++) begin
      lcg = lcg * 1103515245 + 12345;
      line  = N'(lcg >>> 8);
      ack   = lcg[20];
      sa    = (lcg[22:21] == 2'b11);
      sa_id = W'(lcg >>> 23);
      dq    = lcg[26];
      dq_id = W'(lcg >>> 27);
      cyc();
    end
    ack = 0; sa = 0; dq = 0; line = '0;
    cyc();

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule